// File: doc/BRIEF.md
# Dual-Instruction Prefetch Queue

This block sits between the instruction bus and the instruction register of a core whose instructions are 16 bits wide while its bus is 32 bits wide. Every bus access returns one aligned 32-bit word, which the queue stores whole and later releases as two 16-bit instructions. Two such words are kept, so up to four instructions wait ready for decode. Decode pulls one instruction at a time with a take strobe and does not see the latency of individual fetches.

A new fetch is requested only when a complete 32-bit entry is free and no earlier fetch is still in flight. The bus therefore carries one access per two instructions, and other bus masters get the remaining cycles. A flush with a redirect address empties the queue, discards any response still in flight, and restarts fetching at the word that holds the redirect target. If the target is the upper halfword of that word, the lower one is never handed out.

Top module: `pfq_top`

## Requirements
- R1: Within a fetched word, bits [15:0] (lower address) are issued before bits [31:16], and instructions reach decode in strictly ascending halfword address order between flushes.
- R2: At most one fetch is outstanding; once a request is accepted (`fetch_req_o` and `fetch_ack_i` both high), `fetch_req_o` is low in the next cycle and stays low until the response arrives.
- R3: While a request waits for acceptance its address is unchanged; it is always 32-bit aligned, and each accepted request advances the next fetch address by 4.
- R4: `insn_valid_o` is high exactly when at least one instruction is buffered; a response becomes visible to decode in the cycle after it arrives, and an empty queue keeps `insn_valid_o` low until then.
- R5: While `insn_valid_o` is high and decode does not take, the presented instruction stays the same in the next cycle.
- R6: A flush empties both entries (`insn_valid_o` low in the next cycle), and the response of any fetch accepted before the flush is dropped, including one that arrives in the flush cycle.
- R7: After a flush the next fetch address is the redirect address with bits [1:0] cleared; when redirect bit 1 is set, the lower halfword of the first word fetched is discarded.
- R8: A response can be written into a free entry in the same cycle that decode takes an instruction from the other entry, with no loss or reordering.
- R9: After reset both entries are empty and a fetch is requested at the reset address parameter (default 0).
- R10: Outside a flush cycle, a request is raised whenever an entry is free and no fetch is outstanding; equivalently it is raised exactly when two or fewer instructions are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Discard queue contents and redirect fetching |
| redirect_i | input | ADDR_W | Byte address of the new instruction stream (halfword aligned) |
| fetch_req_o | output | 1 | Fetch request to the bus |
| fetch_addr_o | output | ADDR_W | Word-aligned fetch address |
| fetch_ack_i | input | 1 | Bus accepts the current request |
| rsp_valid_i | input | 1 | Fetch response data is valid |
| rsp_data_i | input | 32 | Fetched word, lower address in bits [15:0] |
| insn_valid_o | output | 1 | An instruction is presented to decode |
| insn_o | output | 16 | Presented instruction |
| insn_take_i | input | 1 | Decode takes the presented instruction |

## Verification
The two functions that can fall in one cycle are a response being written into the free entry and decode taking the last or first instruction of the other entry; a flush can also coincide with a response arriving. The bench provokes both with random acceptance, random response delay and decode phases that alternate between eager and sparse taking, plus forced flushes while a fetch is in flight. It judges them by checking every released instruction against a halfword-address-derived pattern, by tracking the held instruction count against `insn_valid_o` and `fetch_req_o`, and by counting that the write-plus-take coincidence actually occurred.

// File: rtl/pfq_pkg.sv
// Package: shared widths and types for the prefetch queue.
// Assumes two instructions per bus word and two buffered words.
package pfq_pkg;
    localparam int INSN_W  = 16;
    localparam int WORD_W  = 2 * INSN_W;
    localparam int ENTRIES = 2;
    localparam int BYTES_PER_WORD = WORD_W / 8;

    typedef logic [INSN_W-1:0] insn_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [1:0]        half_vld_t;   // bit0 = lower halfword, bit1 = upper
endpackage

// File: rtl/pfq_slot.sv
// Module: pfq_slot
// One 32-bit queue entry with a valid bit per halfword.
// Assumes the owner writes only when the entry is empty and takes only
// when it is not; a take consumes the lower valid halfword first.
module pfq_slot
    import pfq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      wr_en,
    input  logic      wr_skip,
    input  word_t     wr_data,
    input  logic      take,
    output half_vld_t vld,
    output word_t     data
);

    // Halfword valid tracking: clear, fill, or consume one halfword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr) begin
            vld <= '0;
        end else if (wr_en) begin
            vld <= wr_skip ? 2'b10 : 2'b11;
        end else if (take) begin
            if (vld[0]) vld[0] <= 1'b0;
            else        vld[1] <= 1'b0;
        end
    end

    // Word storage, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     data <= '0;
        else if (wr_en) data <= wr_data;
    end

endmodule

// File: rtl/pfq_fetch_ctl.sv
// Module: pfq_fetch_ctl
// Issues word fetches, tracks the single outstanding access, drops the
// response of an access overtaken by a flush, and remembers whether the
// first word after a redirect must lose its lower halfword.
// Assumes the bus returns exactly one response per accepted request.
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] RESET_ADDR = 32'h0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] redir,
    input  logic              has_free,
    input  logic              ack,
    input  logic              rsp_valid,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              wr_skip
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BYTES_PER_WORD);
    localparam logic [ADDR_W-1:0] BOOT     = ADDR_W'(RESET_ADDR);
    localparam logic [ADDR_W-1:0] ALIGN_MK = ~ADDR_W'(BYTES_PER_WORD - 1);

    logic outstanding;
    logic drop;
    logic skip;

    // Request only with a free entry, an idle bus and no flush this cycle.
    assign req     = has_free && !outstanding && !flush;
    // Accept response data unless stale or overtaken by a flush.
    assign wr_en   = rsp_valid && outstanding && !drop && !flush;
    assign wr_skip = skip;

    // Next fetch address: redirect, advance on acceptance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          addr <= BOOT & ALIGN_MK;
        else if (flush)      addr <= redir & ALIGN_MK;
        else if (req && ack) addr <= addr + STEP;
    end

    // Single outstanding access, cleared by its response.
    always_ff @(posedge clk) begin
        if (!rst_n)          outstanding <= 1'b0;
        else if (rsp_valid)  outstanding <= 1'b0;
        else if (req && ack) outstanding <= 1'b1;
    end

    // Stale-response marker set when a flush overtakes an access.
    always_ff @(posedge clk) begin
        if (!rst_n)         drop <= 1'b0;
        else if (flush)     drop <= outstanding && !rsp_valid;
        else if (rsp_valid) drop <= 1'b0;
    end

    // Lower-halfword discard for the first word after an odd redirect.
    always_ff @(posedge clk) begin
        if (!rst_n)     skip <= 1'b0;
        else if (flush) skip <= redir[1];
        else if (wr_en) skip <= 1'b0;
    end

endmodule

// File: rtl/pfq_top.sv
// Module: pfq_top
// Two-entry prefetch queue holding up to four 16-bit instructions.
// Words are written in fetch order and read in the same order; decode
// sees the oldest halfword combinationally from the head entry.
// Assumes redirect addresses are halfword aligned (bit 0 is ignored).
module pfq_top
    import pfq_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] RESET_ADDR = 32'h0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] redirect_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_ack_i,
    input  logic              rsp_valid_i,
    input  logic [WORD_W-1:0] rsp_data_i,
    output logic              insn_valid_o,
    output logic [INSN_W-1:0] insn_o,
    input  logic              insn_take_i
);

    half_vld_t slot_vld  [ENTRIES];
    word_t     slot_data [ENTRIES];

    logic      rd_ptr;
    logic      wr_ptr;
    logic      has_free;
    logic      fill;
    logic      fill_skip;
    logic      take_fire;
    logic      head_last;
    half_vld_t head_vld;
    word_t     head_data;

    assign head_vld  = slot_vld[rd_ptr];
    assign head_data = slot_data[rd_ptr];
    assign has_free  = ~|slot_vld[wr_ptr];

    pfq_fetch_ctl #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_i),
        .redir     (redirect_i),
        .has_free  (has_free),
        .ack       (fetch_ack_i),
        .rsp_valid (rsp_valid_i),
        .req       (fetch_req_o),
        .addr      (fetch_addr_o),
        .wr_en     (fill),
        .wr_skip   (fill_skip)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        pfq_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (flush_i),
            .wr_en   (fill && (wr_ptr == 1'(g))),
            .wr_skip (fill_skip),
            .wr_data (rsp_data_i),
            .take    (take_fire && (rd_ptr == 1'(g))),
            .vld     (slot_vld[g]),
            .data    (slot_data[g])
        );
    end

    // Present the lower halfword first, then the upper one.
    always_comb begin
        insn_valid_o = |head_vld;
        insn_o       = head_vld[0] ? head_data[INSN_W-1:0] : head_data[WORD_W-1:INSN_W];
    end

    assign take_fire = insn_valid_o && insn_take_i && !flush_i;
    assign head_last = take_fire && (head_vld != 2'b11);

    // Entry pointers: reset on flush, advance on fill and on draining the head.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            rd_ptr <= 1'b0;
            wr_ptr <= 1'b0;
        end else begin
            if (fill)      wr_ptr <= ~wr_ptr;
            if (head_last) rd_ptr <= ~rd_ptr;
        end
    end

endmodule

// File: rtl/pfq_chk.sv
// Module: pfq_chk
// Port-level temporal checks for pfq_top, attached by bind below.
module pfq_chk
    import pfq_pkg::*;
#(
    parameter int ADDR_W = 32
)(
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              fetch_req_o,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              fetch_ack_i,
    input logic              insn_valid_o,
    input logic [INSN_W-1:0] insn_o,
    input logic              insn_take_i
);

    // R2
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && fetch_ack_i |=> !fetch_req_o);

    // R3
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> fetch_addr_o[1:0] == 2'b00);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && !fetch_ack_i && !flush_i |=> $stable(fetch_addr_o));

    // R5
    insn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o && !insn_take_i && !flush_i |=> insn_valid_o && $stable(insn_o));

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !insn_valid_o);

endmodule

bind pfq_top pfq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_ack_i  (fetch_ack_i),
    .insn_valid_o (insn_valid_o),
    .insn_o       (insn_o),
    .insn_take_i  (insn_take_i)
);

// File: tb/pfq_top_tb.sv
// Bench for pfq_top: random bus timing, decode pacing and flushes, with a
// reference model of held count, fetch address and instruction order.
module pfq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush_i;
    logic [31:0] redirect_i;
    logic        fetch_req_o;
    logic [31:0] fetch_addr_o;
    logic        fetch_ack_i;
    logic        rsp_valid_i;
    logic [31:0] rsp_data_i;
    logic        insn_valid_o;
    logic [15:0] insn_o;
    logic        insn_take_i;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pfq_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .redirect_i   (redirect_i),
        .fetch_req_o  (fetch_req_o),
        .fetch_addr_o (fetch_addr_o),
        .fetch_ack_i  (fetch_ack_i),
        .rsp_valid_i  (rsp_valid_i),
        .rsp_data_i   (rsp_data_i),
        .insn_valid_o (insn_valid_o),
        .insn_o       (insn_o),
        .insn_take_i  (insn_take_i)
    );

    // Instruction pattern derived from its byte address.
    function automatic logic [15:0] hw(input logic [31:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[8:1], a[16:9]};
    endfunction

    function automatic logic [31:0] word_of(input logic [31:0] w);
        return {hw(w + 32'd2), hw(w)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model state
    int          count;
    logic [31:0] exp_hw, exp_fetch, pend_addr;
    bit          busy, stale, skip, prev_flush, hold_pend;
    int          delay, coincide, odd_redirs;
    logic [15:0] hold_val;

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; flush_i = 0; redirect_i = 0; fetch_ack_i = 0;
        rsp_valid_i = 0; rsp_data_i = 0; insn_take_i = 0;
        count = 0; exp_hw = 0; exp_fetch = 0; busy = 0; stale = 0; skip = 0;
        prev_flush = 0; hold_pend = 0; delay = 0; coincide = 0; odd_redirs = 0;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        check(insn_valid_o == 1'b0, "R9 valid", 32'(insn_valid_o), 0);
        check(fetch_req_o == 1'b1,  "R9 req",   32'(fetch_req_o), 1);
        check(fetch_addr_o == 32'h0, "R9 addr", fetch_addr_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 4000; cyc++) begin
            int  phase;
            bit  newly;
            if (cyc > 0) @(negedge clk);
            phase = (cyc / 64) % 3;
            // Drive stimulus
            flush_i    = ($urandom % 60) == 0;
            if ((cyc % 97) == 50 && busy) flush_i = 1'b1;      // flush with fetch in flight
            redirect_i = {16'h0, 15'($urandom), 1'b0};
            if ((cyc % 97) == 50) redirect_i[1] = 1'b1;        // odd-halfword target
            fetch_ack_i = ($urandom % 4) != 0;
            case (phase)
                0:       insn_take_i = ($urandom % 10) != 0;
                1:       insn_take_i = ($urandom % 5) == 0;
                default: insn_take_i = $urandom % 2;
            endcase
            rsp_valid_i = busy && (delay == 0);
            rsp_data_i  = rsp_valid_i ? word_of(pend_addr) : 32'h0;
            #1;
            // Output checks
            if (prev_flush)
                check(insn_valid_o == (count > 0), "R6 empty after flush", 32'(insn_valid_o), 32'(count > 0));
            else
                check(insn_valid_o == (count > 0), "R4 valid vs held", 32'(insn_valid_o), 32'(count > 0));
            check(fetch_req_o == (!flush_i && !busy && count <= 2), "R10 R2 request",
                  32'(fetch_req_o), 32'(!flush_i && !busy && count <= 2));
            if (fetch_req_o)
                check(fetch_addr_o == exp_fetch, "R3 R7 fetch addr", fetch_addr_o, exp_fetch);
            if (hold_pend)
                check(insn_valid_o && insn_o == hold_val, "R5 hold", 32'(insn_o), 32'(hold_val));
            if (insn_valid_o && insn_take_i && !flush_i) begin
                if (rsp_valid_i && !stale)
                    check(insn_o == hw(exp_hw), "R8 take during fill", 32'(insn_o), 32'(hw(exp_hw)));
                else
                    check(insn_o == hw(exp_hw), "R1 R7 order", 32'(insn_o), 32'(hw(exp_hw)));
            end
            if (rsp_valid_i && !stale && !flush_i && insn_valid_o && insn_take_i) coincide++;
            hold_pend = insn_valid_o && !insn_take_i && !flush_i;
            hold_val  = insn_o;
            // Model update for the coming edge
            newly = 0;
            if (flush_i) begin
                count = 0; exp_hw = redirect_i; exp_fetch = redirect_i & ~32'h3;
                skip = redirect_i[1];
                if (skip) odd_redirs++;
                if (rsp_valid_i) begin busy = 0; stale = 0; end
                else if (busy) stale = 1;
            end else begin
                if (insn_valid_o && insn_take_i) begin count--; exp_hw += 2; end
                if (rsp_valid_i) begin
                    busy = 0;
                    if (stale) stale = 0;
                    else begin count += skip ? 1 : 2; skip = 0; end
                end
                if (fetch_req_o && fetch_ack_i) begin
                    busy = 1; pend_addr = fetch_addr_o; exp_fetch += 4;
                    delay = $urandom % 3; newly = 1;
                end
            end
            if (busy && !rsp_valid_i && !newly && delay > 0) delay--;
            prev_flush = flush_i;
        end
        @(negedge clk);
        check(coincide > 0, "R8 coincidence seen", 32'(coincide), 1);
        check(odd_redirs > 0, "R7 odd redirect seen", 32'(odd_redirs), 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule